// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block is a circular buffer that holds every in-flight instruction from issue until it retires, so that results computed out of order reach architectural state strictly in program order. The issue stage allocates one entry per instruction. Each entry records an operation class, a destination, a result value and a ready flag. The entry number returned by the allocation serves as the instruction's tag. Execution units broadcast results tagged with that entry number. The issue stage may also read a finished result straight out of an entry instead of waiting for it.

Only the oldest entry (the head) may retire, and only once its result is present. A register-class entry then drives a register-file write. A store-class entry drives a memory write, so memory changes only at retirement. A branch-class entry that was mispredicted retires, raises a flush for one cycle and discards every younger entry, so none of them ever updates state.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: alloc_ready is 1, alloc_tag is 0, and cm_reg_we, cm_mem_we and flush are 0.
- R2: Accepted allocations receive entry numbers 0, 1, 2 and so on, wrapping to 0 after DEPTH-1. alloc_ready is 0 while DEPTH entries are held. An allocation offered while alloc_ready is 0 is ignored, and alloc_tag does not move.
- R3: A result write (wr_valid with wr_tag) to a held entry stores wr_value and marks the entry ready. A write to an entry that is not held is ignored, and that entry still reads as not ready.
- R4: rd_ready is 1 in the same cycle exactly when entry rd_tag is held and ready, and rd_value then gives its stored value.
- R5: Retirement happens only from the head and only when the head is ready, at most one entry per cycle, in allocation order. An entry of op code 0 (register class) retires with cm_reg_we=1, cm_reg_idx equal to its allocated destination, and cm_reg_data equal to its value.
- R6: An entry of op code 1 (store) drives cm_mem_we=1 only in the cycle it retires, with cm_mem_addr taken from the wr_addr of its result write and cm_mem_data from its value. It never does so while it is behind an older entry that is not ready, even if its own result is present.
- R7: An entry of op code 2 (branch) retires without any register or memory write. If its result write carried wr_mispred=1, flush is 1 in its retirement cycle and every younger entry is discarded: none of them ever retires or reads as ready, and the next allocation receives the entry number just after the branch.
- R8: In a cycle with flush=1, alloc_ready is 0 and no allocation takes place.
- R9: When the buffer is not full, an allocation and a retirement in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue offers an instruction |
| alloc_op | input | 2 | Op class: 0 register, 1 store, 2 branch |
| alloc_dst | input | DST_W | Destination register number |
| alloc_ready | output | 1 | Allocation accepted this cycle if offered |
| alloc_tag | output | TAG_W | Entry number given to the offered instruction |
| wr_valid | input | 1 | Result broadcast valid |
| wr_tag | input | TAG_W | Entry the result belongs to |
| wr_value | input | XLEN | Result value, or store data |
| wr_addr | input | DST_W | Store address (used by store entries) |
| wr_mispred | input | 1 | Branch outcome differs from prediction |
| rd_tag | input | TAG_W | Entry to read an operand from |
| rd_ready | output | 1 | Entry rd_tag holds a finished result |
| rd_value | output | XLEN | Value of entry rd_tag |
| cm_reg_we | output | 1 | Register-file write at retirement |
| cm_reg_idx | output | DST_W | Register to write |
| cm_reg_data | output | XLEN | Data to write |
| cm_mem_we | output | 1 | Memory write at retirement |
| cm_mem_addr | output | DST_W | Store address |
| cm_mem_data | output | XLEN | Store data |
| flush | output | 1 | Mispredicted branch retiring; younger entries discarded |

## Verification
On every cycle the embedded properties check that occupancy never passes DEPTH and moves by at most one except through a flush. They also check that register write, memory write and flush never coincide, that a flush is followed by a cycle with no retirement, and that a result written into a held entry leaves it ready. The bench scenarios cover the rest: tag wrap order, holding back a finished store behind an unfinished older entry, ignored writes to free entries, suppression of allocation during a flush, and the squashing of ready younger entries behind a mispredicted branch. These are compared cycle by cycle against a bench-side model of the requirements.

// File: rtl/rob_pkg.sv
package rob_pkg;
   typedef enum logic [1:0] {
      OP_REG    = 2'd0,
      OP_STORE  = 2'd1,
      OP_BRANCH = 2'd2
   } rob_op_e;
endpackage

// File: rtl/rob_entry.sv
module rob_entry #(
   parameter int XLEN  = 32,
   parameter int DST_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             alloc_hit,
   input  logic [1:0]       alloc_op,
   input  logic [DST_W-1:0] alloc_dst,
   input  logic             wr_hit,
   input  logic [XLEN-1:0]  wr_value,
   input  logic [DST_W-1:0] wr_addr,
   input  logic             wr_mispred,
   output logic             q_valid,
   output logic             q_ready,
   output logic [1:0]       q_op,
   output logic [DST_W-1:0] q_dst,
   output logic [XLEN-1:0]  q_value,
   output logic             q_mispred
);
   import rob_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid   <= 1'b0;
         q_ready   <= 1'b0;
         q_op      <= 2'd0;
         q_dst     <= '0;
         q_value   <= '0;
         q_mispred <= 1'b0;
      end else if (clear) begin
         q_valid <= 1'b0;
         q_ready <= 1'b0;
      end else if (alloc_hit) begin
         q_valid   <= 1'b1;
         q_ready   <= 1'b0;
         q_op      <= alloc_op;
         q_dst     <= alloc_dst;
         q_mispred <= 1'b0;
      end else if (wr_hit && q_valid) begin
         q_ready   <= 1'b1;
         q_value   <= wr_value;
         q_mispred <= wr_mispred;
         if (q_op == OP_STORE) q_dst <= wr_addr;
      end
   end

   // R3
   write_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && q_valid && !clear && !alloc_hit) |=> (q_ready && q_valid));
endmodule

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
   parameter int DEPTH = 8,
   localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_alloc,
   input  logic             do_commit,
   input  logic             flush,
   output logic [TAG_W-1:0] head,
   output logic [TAG_W-1:0] tail,
   output logic [CNT_W-1:0] count
);
   localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

   function automatic logic [TAG_W-1:0] wrap_inc(input logic [TAG_W-1:0] p);
      return (p == LAST) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else if (flush) begin
         head  <= wrap_inc(head);
         tail  <= wrap_inc(head);
         count <= '0;
      end else begin
         if (do_commit) head <= wrap_inc(head);
         if (do_alloc)  tail <= wrap_inc(tail);
         count <= count + CNT_W'(do_alloc) - CNT_W'(do_commit);
      end
   end

   // R2
   occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R9
   occupancy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> ((count == $past(count)) || (count == $past(count) + 1'b1)
                  || (count + 1'b1 == $past(count))));
endmodule

// File: rtl/rob_core.sv
module rob_core #(
   parameter int DEPTH = 8,
   parameter int XLEN  = 32,
   parameter int DST_W = 16,
   localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_valid,
   input  logic [1:0]       alloc_op,
   input  logic [DST_W-1:0] alloc_dst,
   output logic             alloc_ready,
   output logic [TAG_W-1:0] alloc_tag,
   input  logic             wr_valid,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [XLEN-1:0]  wr_value,
   input  logic [DST_W-1:0] wr_addr,
   input  logic             wr_mispred,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_ready,
   output logic [XLEN-1:0]  rd_value,
   output logic             cm_reg_we,
   output logic [DST_W-1:0] cm_reg_idx,
   output logic [XLEN-1:0]  cm_reg_data,
   output logic             cm_mem_we,
   output logic [DST_W-1:0] cm_mem_addr,
   output logic [XLEN-1:0]  cm_mem_data,
   output logic             flush
);
   import rob_pkg::*;

   if (DEPTH < 2) begin : g_bad_depth
      $error("rob_core: DEPTH must be at least 2");
   end
   if (XLEN < 1 || DST_W < 1) begin : g_bad_width
      $error("rob_core: XLEN and DST_W must be positive");
   end

   logic [TAG_W-1:0] head, tail;
   logic [CNT_W-1:0] count;
   logic             do_alloc, do_commit, head_live;

   logic             e_valid   [DEPTH];
   logic             e_ready   [DEPTH];
   logic [1:0]       e_op      [DEPTH];
   logic [DST_W-1:0] e_dst     [DEPTH];
   logic [XLEN-1:0]  e_value   [DEPTH];
   logic             e_mispred [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      logic hit_alloc, hit_wr, hit_clear;
      assign hit_alloc = do_alloc && (tail == TAG_W'(i));
      assign hit_wr    = wr_valid && (wr_tag == TAG_W'(i));
      assign hit_clear = flush || (do_commit && (head == TAG_W'(i)));
      rob_entry #(.XLEN(XLEN), .DST_W(DST_W)) u_entry (
         .clk(clk), .rst_n(rst_n), .clear(hit_clear),
         .alloc_hit(hit_alloc), .alloc_op(alloc_op), .alloc_dst(alloc_dst),
         .wr_hit(hit_wr), .wr_value(wr_value), .wr_addr(wr_addr),
         .wr_mispred(wr_mispred),
         .q_valid(e_valid[i]), .q_ready(e_ready[i]), .q_op(e_op[i]),
         .q_dst(e_dst[i]), .q_value(e_value[i]), .q_mispred(e_mispred[i])
      );
   end

   rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .do_alloc(do_alloc), .do_commit(do_commit),
      .flush(flush), .head(head), .tail(tail), .count(count)
   );

   always_comb begin
      head_live   = e_valid[head] && e_ready[head];
      do_commit   = head_live;
      flush       = head_live && (e_op[head] == OP_BRANCH) && e_mispred[head];
      alloc_ready = (count != CNT_W'(DEPTH)) && !flush;
      do_alloc    = alloc_valid && alloc_ready;
      alloc_tag   = tail;
      cm_reg_we   = head_live && (e_op[head] == OP_REG);
      cm_reg_idx  = e_dst[head];
      cm_reg_data = e_value[head];
      cm_mem_we   = head_live && (e_op[head] == OP_STORE);
      cm_mem_addr = e_dst[head];
      cm_mem_data = e_value[head];
      rd_ready    = e_valid[rd_tag] && e_ready[rd_tag];
      rd_value    = e_value[rd_tag];
   end

   // R5
   single_retire_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cm_reg_we, cm_mem_we, flush}));

   // R7
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!cm_reg_we && !cm_mem_we && !flush && !rd_ready));

   // R8
   flush_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> $stable(alloc_tag) || (alloc_tag == $past(head) + 1'b1) || ($past(head) == TAG_W'(DEPTH - 1)));
endmodule

// File: tb/sim_rob_core.sv
module sim_rob_core;
   localparam int DEPTH = 8;
   localparam int XLEN  = 32;
   localparam int DST_W = 16;
   localparam int TAG_W = 3;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             alloc_valid;
   logic [1:0]       alloc_op;
   logic [DST_W-1:0] alloc_dst;
   logic             alloc_ready;
   logic [TAG_W-1:0] alloc_tag;
   logic             wr_valid;
   logic [TAG_W-1:0] wr_tag;
   logic [XLEN-1:0]  wr_value;
   logic [DST_W-1:0] wr_addr;
   logic             wr_mispred;
   logic [TAG_W-1:0] rd_tag;
   logic             rd_ready;
   logic [XLEN-1:0]  rd_value;
   logic             cm_reg_we, cm_mem_we, flush;
   logic [DST_W-1:0] cm_reg_idx, cm_mem_addr;
   logic [XLEN-1:0]  cm_reg_data, cm_mem_data;

   always #10 clk = ~clk;

   rob_core #(.DEPTH(DEPTH), .XLEN(XLEN), .DST_W(DST_W)) u0 (
      .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_op(alloc_op),
      .alloc_dst(alloc_dst), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
      .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_value(wr_value), .wr_addr(wr_addr),
      .wr_mispred(wr_mispred), .rd_tag(rd_tag), .rd_ready(rd_ready),
      .rd_value(rd_value), .cm_reg_we(cm_reg_we), .cm_reg_idx(cm_reg_idx),
      .cm_reg_data(cm_reg_data), .cm_mem_we(cm_mem_we), .cm_mem_addr(cm_mem_addr),
      .cm_mem_data(cm_mem_data), .flush(flush)
   );

   int n_tests = 0;
   int n_fail  = 0;

   bit               m_valid [DEPTH];
   bit               m_ready [DEPTH];
   logic [1:0]       m_op    [DEPTH];
   logic [DST_W-1:0] m_dst   [DEPTH];
   logic [XLEN-1:0]  m_val   [DEPTH];
   bit               m_mis   [DEPTH];
   int               m_head, m_tail, m_cnt;

   function automatic int inc(input int p);
      return (p == DEPTH - 1) ? 0 : p + 1;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      alloc_valid = 0; alloc_op = 0; alloc_dst = 0;
      wr_valid = 0; wr_tag = 0; wr_value = 0; wr_addr = 0; wr_mispred = 0;
      rd_tag = 0;
   endtask

   task automatic model_reset();
      for (int i = 0; i < DEPTH; i++) begin
         m_valid[i] = 0; m_ready[i] = 0; m_op[i] = 0;
         m_dst[i] = 0; m_val[i] = 0; m_mis[i] = 0;
      end
      m_head = 0; m_tail = 0; m_cnt = 0;
   endtask

   task automatic do_reset();
      idle_inputs();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      model_reset();
   endtask

   // Called in the low clock phase with inputs already driven.
   task automatic cycle();
      bit hv, e_flush, e_ar, e_alloc;
      #1;
      hv      = m_valid[m_head] && m_ready[m_head];
      e_flush = hv && (m_op[m_head] == 2'd2) && m_mis[m_head];
      e_ar    = (m_cnt != DEPTH) && !e_flush;
      e_alloc = alloc_valid && e_ar;
      chk(e_flush ? "R8" : "R2", "alloc_ready", 64'(alloc_ready), 64'(e_ar));
      chk((hv && e_alloc) ? "R9" : "R2", "alloc_tag", 64'(alloc_tag), 64'(m_tail));
      chk("R5", "cm_reg_we", 64'(cm_reg_we), 64'(hv && m_op[m_head] == 2'd0));
      if (hv && m_op[m_head] == 2'd0) begin
         chk("R5", "cm_reg_idx", 64'(cm_reg_idx), 64'(m_dst[m_head]));
         chk("R5", "cm_reg_data", 64'(cm_reg_data), 64'(m_val[m_head]));
      end
      chk("R6", "cm_mem_we", 64'(cm_mem_we), 64'(hv && m_op[m_head] == 2'd1));
      if (hv && m_op[m_head] == 2'd1) begin
         chk("R6", "cm_mem_addr", 64'(cm_mem_addr), 64'(m_dst[m_head]));
         chk("R6", "cm_mem_data", 64'(cm_mem_data), 64'(m_val[m_head]));
      end
      chk("R7", "flush", 64'(flush), 64'(e_flush));
      chk("R3", "rd_ready", 64'(rd_ready), 64'(m_valid[rd_tag] && m_ready[rd_tag]));
      if (m_valid[rd_tag] && m_ready[rd_tag])
         chk("R4", "rd_value", 64'(rd_value), 64'(m_val[rd_tag]));
      @(posedge clk);
      if (wr_valid && m_valid[wr_tag]) begin
         m_ready[wr_tag] = 1;
         m_val[wr_tag]   = wr_value;
         m_mis[wr_tag]   = wr_mispred;
         if (m_op[wr_tag] == 2'd1) m_dst[wr_tag] = wr_addr;
      end
      if (e_flush) begin
         for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 0; m_ready[i] = 0;
         end
         m_head = inc(m_head); m_tail = m_head; m_cnt = 0;
      end else begin
         if (hv) begin
            m_valid[m_head] = 0; m_ready[m_head] = 0;
            m_head = inc(m_head); m_cnt--;
         end
         if (e_alloc) begin
            m_valid[m_tail] = 1; m_ready[m_tail] = 0;
            m_op[m_tail] = alloc_op; m_dst[m_tail] = alloc_dst; m_mis[m_tail] = 0;
            m_tail = inc(m_tail); m_cnt++;
         end
      end
      @(negedge clk);
   endtask

   task automatic alloc1(input logic [1:0] op, input logic [DST_W-1:0] dst);
      idle_inputs();
      alloc_valid = 1; alloc_op = op; alloc_dst = dst;
      cycle();
   endtask

   task automatic write1(input int tag, input logic [XLEN-1:0] v,
                         input logic [DST_W-1:0] a, input bit mis);
      idle_inputs();
      wr_valid = 1; wr_tag = TAG_W'(tag); wr_value = v; wr_addr = a; wr_mispred = mis;
      rd_tag = TAG_W'(tag);
      cycle();
   endtask

   task automatic read1(input int tag);
      idle_inputs();
      rd_tag = TAG_W'(tag);
      cycle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      // R1 reset state
      #1;
      chk("R1", "alloc_ready", 64'(alloc_ready), 64'd1);
      chk("R1", "alloc_tag", 64'(alloc_tag), 64'd0);
      chk("R1", "cm_reg_we", 64'(cm_reg_we), 64'd0);
      chk("R1", "cm_mem_we", 64'(cm_mem_we), 64'd0);
      chk("R1", "flush", 64'(flush), 64'd0);
      @(negedge clk);

      // R6: finished store behind unfinished register entry
      alloc1(2'd0, 16'h5);
      alloc1(2'd1, 16'h0);
      write1(1, 32'hAA, 16'h100, 0);
      read1(1);
      read1(1);
      write1(0, 32'h7, 16'h0, 0);
      read1(0);
      read1(0);

      // R3: write to a free entry is ignored
      write1(5, 32'h1234, 16'h0, 0);
      read1(5);

      // R2: fill to DEPTH, then try one more
      for (int k = 0; k < DEPTH; k++) alloc1(2'd0, DST_W'(k + 1));
      alloc1(2'd0, 16'h77);
      alloc1(2'd0, 16'h78);
      // R9: make head ready, then allocate while it retires
      write1(m_head, 32'h55, 16'h0, 0);
      alloc1(2'd0, 16'h79);
      write1(m_head, 32'h56, 16'h0, 0);
      alloc1(2'd0, 16'h7A);

      // R7 and R8: mispredicted branch with finished younger entries
      do_reset();
      alloc1(2'd2, 16'h0);
      alloc1(2'd0, 16'h3);
      alloc1(2'd1, 16'h0);
      alloc1(2'd0, 16'h4);
      write1(1, 32'h11, 16'h0, 0);
      write1(2, 32'h22, 16'h40, 0);
      write1(0, 32'h0, 16'h0, 1);
      alloc1(2'd0, 16'h9);   // offered in the flush cycle
      read1(1);
      read1(2);
      alloc1(2'd0, 16'hA);

      // constrained random traffic
      for (int c = 0; c < 4000; c++) begin
         idle_inputs();
         alloc_valid = ($urandom % 4) != 0;
         alloc_op    = 2'($urandom % 3);
         alloc_dst   = DST_W'($urandom);
         wr_valid    = ($urandom % 3) != 0;
         wr_tag      = TAG_W'($urandom % DEPTH);
         wr_value    = $urandom;
         wr_addr     = DST_W'($urandom);
         wr_mispred  = ($urandom % 6) == 0;
         rd_tag      = TAG_W'($urandom % DEPTH);
         cycle();
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule